// File: doc/BRIEF.md
# Static memory bus timing controller

This block sequences accesses to asynchronous parallel memories on an external bus that has six chip selects. An internal requester presents an address, write data, a direction flag and a chip-select index. The block checks that the selected chip select is enabled. It then drives chip select, output enable, write enable, address valid, the address and the write data. The length of each phase comes from timing fields held separately for each chip select. When the access finishes, the block returns a one-cycle done pulse. For a read, the pulse carries the captured read data.

The controller adds a bus turnaround gap only where a device may still be driving the data lines. That is the case when a read is followed by an access to a different chip select, or by a write to the same chip select. The length of the gap comes from the chip select that was just read. Three per-select settings shape the read lead-in: a chip-select-to-OE hold, an ADV-to-OE spacing and an optional extra address-hold cycle. The enables and the timing words are written through a flat register port.

Top module: `smc_xbus`

## Requirements
- R1: After reset, every enable bit is clear, all chip selects and strobes are high (inactive), the data output enable is low, and `req_ready` is high. A request made before any configuration completes with `rsp_err` set.
- R2: The enable word is at config address 0x10. Its bits are: chip select 0 at bits 1:0, 1 at bits 3:2, 2 at bit 4, 3 at bit 5, 4 at bits 7:6, 5 at bits 9:8. A chip select is enabled when any of its bits is set. A request to a disabled chip select, or to an index of 6 or 7, gets `rsp_done` with `rsp_err` one cycle after acceptance, and no bus signal toggles.
- R3: For a read, chip select n is low for L cycles before OE falls. L is the larger of two values: the read-hold field, and the ADV-to-OE field plus the address-hold bit. The fast word at address 0x08+n holds the read-hold field in bits 27:24, the ADV-to-OE field in bits 17:16 and the address-hold bit in bit 5. ADV is low only in the first cycle with chip select low.
- R4: OE stays low for RD_WAIT+1 cycles. RD_WAIT is bits 3:0 of the slow word at address 0x00+n. Read data is sampled on the last OE-low cycle, and `rsp_done` follows in the next cycle.
- R5: For a write, WE is low from the first chip-select cycle for WR_WAIT+1 cycles. WR_WAIT is bits 7:4 of the slow word. The address and write data are driven with `mem_dq_oe` high.
- R6: After WE rises, chip select stays low and data stays driven for the larger of WR_HOLD (slow bits 27:24) and 1 cycles.
- R7: A read followed by an accepted access to another chip select, or by a write to the same chip select, is preceded by RECOVERY+1 idle bus cycles. RECOVERY is slow bits 31:28 of the chip select that was read.
- R8: No idle gap is inserted after a write, or between reads on the same chip select. A rejected request does not change which access counts as the last one.
- R9: `mem_dq_oe` is never high while OE is low or while no chip select is active.
- R10: At most one chip select is low at a time. `req_ready` is high only when the bus is idle. A new request is accepted in the same cycle as the previous `rsp_done`.
- R11: Bits 23:8 of a slow word have no effect on any timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Chip-select index |
| req_addr | input | AW | Memory address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected (valid with done) |
| rsp_rdata | output | DW | Captured read data |
| mem_cs_n | output | 6 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_adv_n | output | 1 | Active-low address valid |
| mem_addr | output | AW | Memory address |
| mem_dq_o | output | DW | Write data out |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DW | Read data in |

## Verification
Completion of one access and acceptance of the next fall in the same cycle. That same clock edge also makes the recovery decision from the last-access record, which the completing access has just updated. The stimulus table runs every request back to back: each request is driven in the cycle where the previous `rsp_done` is seen. So any slip in updating the record shows up as a wrong count of idle cycles before the next chip select falls. The table includes a rejected request placed between a read and a write on another chip select. That placement shows that a reject completing in the acceptance cycle leaves the turnaround decision untouched.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int NCS  = 6;
  localparam int CSW  = 3;
  localparam int ENW  = 10;

  // slow word field positions
  localparam int REC_LSB   = 28;
  localparam int WHOLD_LSB = 24;
  localparam int WWAIT_LSB = 4;
  localparam int RWAIT_LSB = 0;
  // fast word field positions
  localparam int RHOLD_LSB = 24;
  localparam int ADVOE_LSB = 16;
  localparam int AHOLD_BIT = 5;

  typedef struct packed {
    logic [3:0] rec;
    logic [3:0] wr_hold;
    logic [3:0] wr_wait;
    logic [3:0] rd_wait;
    logic [3:0] rd_hold;
    logic [1:0] adv_oe;
    logic       ahold;
  } tmg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECOV, ST_LEAD, ST_RDW, ST_WRW, ST_HOLD
  } seq_st_t;

  function automatic logic cs_enabled(logic [ENW-1:0] en, logic [CSW-1:0] idx);
    case (idx)
      3'd0:    return |en[1:0];
      3'd1:    return |en[3:2];
      3'd2:    return en[4];
      3'd3:    return en[5];
      3'd4:    return |en[7:6];
      3'd5:    return |en[9:8];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] read_lead(tmg_t t);
    logic [3:0] adv_sp;
    adv_sp = {2'b00, t.adv_oe} + {3'b000, t.ahold};
    return (t.rd_hold > adv_sp) ? t.rd_hold : adv_sp;
  endfunction
endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int CAW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CAW-1:0]   cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [ENW-1:0]   en_o,
  output tmg_t             tmg_o [NCS]
);
  localparam logic [CAW-1:0] ADR_EN   = CAW'(16);
  localparam int             SLOW_BASE = 0;
  localparam int             FAST_BASE = 8;

  logic [ENW-1:0] en_q;
  logic           en_wr;

  assign en_wr = cfg_we && (cfg_addr == ADR_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= cfg_wdata[ENW-1:0];
  end
  assign en_o = en_q;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    logic [15:0] slow_q;
    logic [6:0]  fast_q;
    logic        slow_wr, fast_wr;

    assign slow_wr = cfg_we && (cfg_addr == CAW'(SLOW_BASE + g));
    assign fast_wr = cfg_we && (cfg_addr == CAW'(FAST_BASE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slow_q <= '0;
      else if (slow_wr) slow_q <= {cfg_wdata[REC_LSB+:4], cfg_wdata[WHOLD_LSB+:4],
                                   cfg_wdata[WWAIT_LSB+:4], cfg_wdata[RWAIT_LSB+:4]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fast_q <= '0;
      else if (fast_wr) fast_q <= {cfg_wdata[RHOLD_LSB+:4], cfg_wdata[ADVOE_LSB+:2],
                                   cfg_wdata[AHOLD_BIT]};
    end

    assign tmg_o[g] = '{rec: slow_q[15:12], wr_hold: slow_q[11:8], wr_wait: slow_q[7:4],
                        rd_wait: slow_q[3:0], rd_hold: fast_q[6:3], adv_oe: fast_q[2:1],
                        ahold: fast_q[0]};
  end

  // latency fields and other spare bits are deliberately not stored (R11)
  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[23:8], cfg_wdata[31:28] & 4'h0};
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  tmg_t           tmg_i [NCS],
  input  logic           req_valid,
  input  logic           req_ok,
  input  logic           req_write,
  input  logic [CSW-1:0] req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           req_ready,
  output logic           rsp_done,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata,
  output logic [NCS-1:0] mem_cs_n,
  output logic           mem_oe_n,
  output logic           mem_we_n,
  output logic           mem_adv_n,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_dq_o,
  output logic           mem_dq_oe,
  input  logic [DW-1:0]  mem_dq_i
);
  seq_st_t        st_q, st_d;
  logic [3:0]     cnt_q, cnt_d;
  logic           first_q, first_d;
  logic           done_q, done_d, err_q, err_d;
  logic           last_rd_q, last_rd_d;
  logic [CSW-1:0] last_cs_q, last_cs_d;
  logic [CSW-1:0] cs_q;
  logic           wr_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic           cap_req, cap_rd, go, go_wr;
  tmg_t           tm_act, tm_last, go_tm;
  logic [3:0]     go_lead;
  logic           bus_act;

  assign tm_act  = tmg_i[cs_q];
  assign tm_last = tmg_i[last_cs_q];
  assign go_tm   = (st_q == ST_IDLE) ? tmg_i[req_cs] : tm_act;
  assign go_wr   = (st_q == ST_IDLE) ? req_write : wr_q;
  assign go_lead = read_lead(go_tm);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    first_d   = 1'b0;
    done_d    = 1'b0;
    err_d     = 1'b0;
    cap_req   = 1'b0;
    cap_rd    = 1'b0;
    go        = 1'b0;
    last_rd_d = last_rd_q;
    last_cs_d = last_cs_q;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        if (!req_ok) begin
          done_d = 1'b1;
          err_d  = 1'b1;
        end else begin
          cap_req = 1'b1;
          if (last_rd_q && ((req_cs != last_cs_q) || req_write)) begin
            st_d  = ST_RECOV;
            cnt_d = tm_last.rec;
          end else begin
            go = 1'b1;
          end
        end
      end
      ST_RECOV: if (cnt_q == 4'd0) go = 1'b1; else cnt_d = cnt_q - 4'd1;
      ST_LEAD: if (cnt_q == 4'd0) begin
        st_d  = ST_RDW;
        cnt_d = tm_act.rd_wait;
      end else cnt_d = cnt_q - 4'd1;
      ST_RDW: if (cnt_q == 4'd0) begin
        st_d      = ST_IDLE;
        done_d    = 1'b1;
        cap_rd    = 1'b1;
        last_rd_d = 1'b1;
        last_cs_d = cs_q;
      end else cnt_d = cnt_q - 4'd1;
      ST_WRW: if (cnt_q == 4'd0) begin
        st_d  = ST_HOLD;
        cnt_d = (tm_act.wr_hold == 4'd0) ? 4'd0 : tm_act.wr_hold - 4'd1;
      end else cnt_d = cnt_q - 4'd1;
      ST_HOLD: if (cnt_q == 4'd0) begin
        st_d      = ST_IDLE;
        done_d    = 1'b1;
        last_rd_d = 1'b0;
        last_cs_d = cs_q;
      end else cnt_d = cnt_q - 4'd1;
      default: st_d = ST_IDLE;
    endcase
    if (go) begin
      first_d = 1'b1;
      if (go_wr) begin
        st_d  = ST_WRW;
        cnt_d = go_tm.wr_wait;
      end else if (go_lead == 4'd0) begin
        st_d  = ST_RDW;
        cnt_d = go_tm.rd_wait;
      end else begin
        st_d  = ST_LEAD;
        cnt_d = go_lead - 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      first_q   <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      last_rd_q <= 1'b0;
      last_cs_q <= '0;
      cs_q      <= '0;
      wr_q      <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      first_q   <= first_d;
      done_q    <= done_d;
      err_q     <= err_d;
      last_rd_q <= last_rd_d;
      last_cs_q <= last_cs_d;
      if (cap_req) begin
        cs_q <= req_cs;
        wr_q <= req_write;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cap_req) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
    if (cap_rd) rdata_q <= mem_dq_i;
  end

  assign bus_act = (st_q == ST_LEAD) || (st_q == ST_RDW) || (st_q == ST_WRW) || (st_q == ST_HOLD);
  for (genvar g = 0; g < NCS; g++) begin : g_csn
    assign mem_cs_n[g] = !(bus_act && (cs_q == CSW'(g)));
  end
  assign mem_oe_n  = (st_q != ST_RDW);
  assign mem_we_n  = (st_q != ST_WRW);
  assign mem_adv_n = !first_q;
  assign mem_dq_oe = (st_q == ST_WRW) || (st_q == ST_HOLD);
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign req_ready = (st_q == ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  // R10: never two chip selects at once
  a_r10_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  // R10: ready only with the bus quiet
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&mem_cs_n && mem_oe_n && mem_we_n));
  // R9: no drive while the memory may drive
  a_r9_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);
  // R3: address valid lasts one cycle
  a_r3_adv_single: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n);
  // R5: write strobe only inside a chip-select window
  a_r5_we_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !(&mem_cs_n));
  // R2: a reject leaves the bus quiet
  a_r2_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> (&mem_cs_n && $past(&mem_cs_n)));
endmodule

// File: rtl/smc_xbus.sv
module smc_xbus
  import smc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [4:0]     cfg_addr,
  input  logic [31:0]    cfg_wdata,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [2:0]     req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_done,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata,
  output logic [5:0]     mem_cs_n,
  output logic           mem_oe_n,
  output logic           mem_we_n,
  output logic           mem_adv_n,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_dq_o,
  output logic           mem_dq_oe,
  input  logic [DW-1:0]  mem_dq_i
);
  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic [ENW-1:0] en;
  tmg_t           tmg [NCS];
  logic           req_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign req_ok = cs_enabled(en, req_cs);

  smc_cfg_regs #(.CAW(5)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .en_o(en), .tmg_o(tmg)
  );

  smc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .tmg_i(tmg), .req_valid(req_valid),
    .req_ok(req_ok), .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );
endmodule

// File: tb/smc_xbus_bench.sv
`timescale 1ns/1ps
module smc_xbus_bench;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]    req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_done, rsp_err;
  logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [5:0]    mem_cs_n;
  logic          mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // memory model: returns an address-derived pattern only while OE is low
  assign mem_dq_i = !mem_oe_n ? (mem_addr[15:0] ^ 16'h5A3C) : 16'hFFFF;

  smc_xbus #(.AW(AW), .DW(DW)) u_smc_xbus (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_adv_n(mem_adv_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  typedef struct packed {
    logic       wr;
    logic [2:0] cs;
    logic       err;
    logic [4:0] rec;
    logic [3:0] lead;
    logic [4:0] wt;
    logic [3:0] hold;
  } vec_t;

  // wr, cs, err, idle gap, lead, strobe cycles, hold
  localparam vec_t VECS [12] = '{
    '{1'b0, 3'd0, 1'b0, 5'd0, 4'd1, 5'd3,  4'd0},
    '{1'b0, 3'd0, 1'b0, 5'd0, 4'd1, 5'd3,  4'd0},
    '{1'b1, 3'd0, 1'b0, 5'd3, 4'd0, 5'd2,  4'd1},
    '{1'b0, 3'd1, 1'b0, 5'd0, 4'd3, 5'd1,  4'd0},
    '{1'b0, 3'd2, 1'b0, 5'd1, 4'd0, 5'd16, 4'd0},
    '{1'b1, 3'd2, 1'b0, 5'd5, 4'd0, 5'd4,  4'd2},
    '{1'b1, 3'd4, 1'b0, 5'd0, 4'd0, 5'd1,  4'd1},
    '{1'b0, 3'd3, 1'b1, 5'd0, 4'd0, 5'd0,  4'd0},
    '{1'b0, 3'd4, 1'b0, 5'd0, 4'd3, 5'd2,  4'd0},
    '{1'b0, 3'd5, 1'b1, 5'd0, 4'd0, 5'd0,  4'd0},
    '{1'b1, 3'd1, 1'b0, 5'd2, 4'd0, 5'd1,  4'd3},
    '{1'b0, 3'd6, 1'b1, 5'd0, 4'd0, 5'd0,  4'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_req(input vec_t v, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int idle_pre = 0, lead = 0, wt = 0, hold = 0, adv = 0, dq_bad = 0, data_bad = 0;
    int multi = 0, rdy_bad = 0, cs_cyc = 0;
    bit seen_cs = 0, seen_strobe = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_cs = v.cs; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) begin
      if ($countones(~mem_cs_n) > 1) multi++;
      if (req_ready) rdy_bad++;
      if (&mem_cs_n) begin
        if (!seen_cs) idle_pre++;
        if (mem_dq_oe) dq_bad++;
      end else begin
        seen_cs = 1; cs_cyc++;
        if (!mem_oe_n) begin
          seen_strobe = 1; wt++;
          if (mem_dq_oe) dq_bad++;
          if (mem_addr !== a) data_bad++;
        end else if (!mem_we_n) begin
          seen_strobe = 1; wt++;
          if (!mem_dq_oe || mem_dq_o !== d || mem_addr !== a) data_bad++;
        end else if (!seen_strobe) lead++;
        else begin
          hold++;
          if (v.wr && (!mem_dq_oe || mem_dq_o !== d)) data_bad++;
        end
        if (!mem_adv_n) adv++;
      end
      @(negedge clk);
    end
    chk("R2 error flag", int'(rsp_err), int'(v.err));
    chk("R10 single chip select and ready low while busy", multi + rdy_bad, 0);
    if (v.err) begin
      chk("R2 rejected request leaves bus quiet", cs_cyc + adv, 0);
    end else begin
      chk(v.rec != 0 ? "R7 recovery gap" : "R8 no recovery gap", idle_pre, int'(v.rec));
      chk("R3 lead cycles before OE", lead, int'(v.lead));
      chk("R3 single ADV cycle", adv, 1);
      chk(v.wr ? "R5 WE cycles" : "R4 OE cycles", wt, int'(v.wt));
      chk("R6 hold cycles", hold, int'(v.hold));
      chk("R9 data drive outside writes", dq_bad, 0);
      chk("R5 address and data on bus", data_bad, 0);
      if (!v.wr) chk("R4 captured read data", int'(rsp_rdata), int'(a[15:0] ^ 16'h5A3C));
      if (v.cs == 3'd4) chk("R11 latency bits ignored", lead + wt, int'(v.lead) + int'(v.wt));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 chip selects idle", int'(mem_cs_n), 63);
    chk("R1 strobes idle", int'({mem_oe_n, mem_we_n, mem_adv_n}), 7);
    chk("R1 no drive", int'(mem_dq_oe), 0);
    chk("R1 ready", int'(req_ready), 1);
    do_req('{1'b0, 3'd0, 1'b1, 5'd0, 4'd0, 5'd0, 4'd0}, 20'h00010, 16'h0);  // R1 enables clear

    cfg_write(5'h10, 32'h0000_00D9);
    cfg_write(5'h00, 32'h2000_0012); cfg_write(5'h08, 32'h0100_0000);
    cfg_write(5'h01, 32'h0300_0000); cfg_write(5'h09, 32'h0002_0020);
    cfg_write(5'h02, 32'h4200_003F); cfg_write(5'h0A, 32'h0000_0000);
    cfg_write(5'h04, 32'h11FF_FF01); cfg_write(5'h0C, 32'h0203_0000);

    // table: requests issued back to back, each in the done cycle of the last
    for (int i = 0; i < 12; i++)
      do_req(VECS[i], AW'(20'h01000 * (i + 1) + i), 16'hC000 | DW'(i));

    // directed: enable layout corners (R2)
    cfg_write(5'h10, 32'h0000_02F8);
    do_req('{1'b0, 3'd0, 1'b1, 5'd0, 4'd0, 5'd0, 4'd0}, 20'h0ABCD, 16'h0);
    do_req('{1'b0, 3'd3, 1'b0, 5'd0, 4'd0, 5'd1, 4'd0}, 20'h03333, 16'h0);
    do_req('{1'b0, 3'd5, 1'b0, 5'd1, 4'd0, 5'd1, 4'd0}, 20'h05555, 16'h0);
    do_req('{1'b1, 3'd5, 1'b0, 5'd1, 4'd0, 5'd1, 4'd1}, 20'h05556, 16'h1234);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule